// File: doc/BRIEF.md
# Shared Bus Request Gating Unit

This unit lives inside one symmetric agent on a processor bus that several agents share. It decides in which cycles the agent may start a new transaction. It does not arbitrate ownership among the symmetric agents and it does not sequence transaction phases. It only grants or withholds the right to issue.

When reset is released, the unit latches the agent's identity from the four active-low bus-request pins. The board wires these pins in a rotating pattern, so the line that the central agent pulls low during power-on appears on a different local pin in each agent. After that, the unit combines three conditions to decide whether a pending request may go out: the shared stall line, the priority-agent request, and a lock flag from the core. The unit also drives its own contribution to the wire-OR stall line while its inbound queue is full.

The stall line may only change and be observed on designated edges. A phase bit alternates on every clock. The drive enable updates on even edges and the line is sampled on odd edges, one clock after it may have moved.

Top module: `bus_req_gate`

## Requirements
- R1: On the first rising clock edge after `rst_n` goes high, `req_pins_n` is captured. If exactly pin i (bit i) is low, `agent_id` becomes i and `id_valid` becomes 1. Both hold until the next reset, whatever the pins do afterwards.
- R2: If no pin or more than one pin is low at capture, `id_error` becomes 1, `id_valid` stays 0, and `agent_id` reads 0.
- R3: While `rst_n` is low, `agent_id`, `id_valid`, `id_error`, `issue_grant` and `stall_drive_en` are all 0.
- R4: Edges after reset release are numbered 0, 1, 2 and so on. `stall_drive_en` takes the value of `queue_full` only at even-numbered edges and holds its value across odd-numbered edges.
- R5: The stall line `stall_in_n` (low = stall) is sampled only at odd-numbered edges. While the last sample showed a stall, no grant is issued. A low pulse that spans only an even edge has no effect.
- R6: While `prio_req_n` is low and `lock_active` is 0, no grant is issued. Once `prio_req_n` returns high, a request that is still pending is granted at the next edge.
- R7: While `prio_req_n` is low and `lock_active` is 1, a pending request is still granted.
- R8: `issue_grant` is registered. It goes high for the cycle after a rising edge at which `req_pending` is 1, `id_valid` is 1, no stall is seen, and the priority and lock rule allows it.
- R9: A request held pending over several cycles receives exactly one single-cycle grant. A new grant needs `req_pending` to drop for at least one edge.
- R10: No grant is issued while `id_valid` is 0, including after a capture error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release triggers ID capture |
| req_pins_n | input | 4 | Local bus-request pins, active low, rotated per agent |
| stall_in_n | input | 1 | Shared wire-OR stall line, active low |
| prio_req_n | input | 1 | Priority-agent request, active low |
| lock_active | input | 1 | Core is inside a locked sequence |
| req_pending | input | 1 | Core has a new request waiting |
| queue_full | input | 1 | Inbound request queue is full |
| agent_id | output | 2 | Captured agent identity |
| id_valid | output | 1 | Capture found exactly one low pin |
| id_error | output | 1 | Capture found zero or several low pins |
| issue_grant | output | 1 | One-cycle permission to issue |
| stall_drive_en | output | 1 | Enable for this agent's stall-line driver |

## Verification
Two functions can act at the same edge. The grant decision reads the stall sample, and the phase logic may refresh that sample at the same edge. When a stall pulse ends just before an odd edge and a request is already pending, the grant at that odd edge still uses the old sample, and the grant only appears one edge later. The bench aligns the stall pulses to an even edge or an odd edge by counting edges since reset release. It checks that the pulse spanning only an even edge is ignored, so the grant comes at once. It checks that the pulse spanning an odd edge delays the grant by exactly two edges.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic {
    PH_DRIVE  = 1'b0,
    PH_SAMPLE = 1'b1
  } phase_e;

  // Grant rule: pending, known identity, no stall seen, and either no
  // priority override or an ongoing locked sequence.
  function automatic logic grant_allowed(
    input logic pending,
    input logic id_ok,
    input logic stall_seen,
    input logic prio_n,
    input logic locked
  );
    return pending & id_ok & ~stall_seen & (prio_n | locked);
  endfunction

endpackage

// File: rtl/brg_id_capture.sv
module brg_id_capture #(
  parameter int unsigned NUM_PINS = 4,
  localparam int unsigned IDW = $clog2(NUM_PINS),
  localparam int unsigned CNTW = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_n,
  output logic [IDW-1:0]      id,
  output logic                valid,
  output logic                error,
  output logic                captured
);

  logic [CNTW-1:0] low_cnt;
  logic [IDW-1:0]  low_idx;

  always_comb begin
    low_cnt = '0;
    low_idx = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!pins_n[i]) begin
        low_cnt = low_cnt + 1'b1;
        low_idx = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      id       <= '0;
      valid    <= 1'b0;
      error    <= 1'b0;
    end else if (!captured) begin
      captured <= 1'b1;
      valid    <= (low_cnt == CNTW'(1));
      error    <= (low_cnt != CNTW'(1));
      id       <= (low_cnt == CNTW'(1)) ? low_idx : '0;
    end
  end

endmodule

// File: rtl/brg_stall_phase.sv
module brg_stall_phase
  import brg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   queue_full,
  input  logic   stall_in_n,
  output logic   drive_en,
  output logic   stall_seen,
  output phase_e phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_DRIVE;
      drive_en   <= 1'b0;
      stall_seen <= 1'b0;
    end else begin
      phase <= (phase == PH_DRIVE) ? PH_SAMPLE : PH_DRIVE;
      if (phase == PH_DRIVE) begin
        drive_en <= queue_full;
      end
      if (phase == PH_SAMPLE) begin
        stall_seen <= ~stall_in_n;
      end
    end
  end

endmodule

// File: rtl/brg_issue_gate.sv
module brg_issue_gate
  import brg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_pending,
  input  logic id_valid,
  input  logic stall_seen,
  input  logic prio_req_n,
  input  logic lock_active,
  output logic grant,
  output logic served
);

  logic allow;

  always_comb begin
    allow = grant_allowed(req_pending, id_valid, stall_seen, prio_req_n, lock_active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= 1'b0;
      served <= 1'b0;
    end else begin
      grant  <= allow & ~served;
      served <= req_pending & (served | allow);
    end
  end

endmodule

// File: rtl/bus_req_gate.sv
module bus_req_gate
  import brg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  localparam int unsigned IDW = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] req_pins_n,
  input  logic                stall_in_n,
  input  logic                prio_req_n,
  input  logic                lock_active,
  input  logic                req_pending,
  input  logic                queue_full,
  output logic [IDW-1:0]      agent_id,
  output logic                id_valid,
  output logic                id_error,
  output logic                issue_grant,
  output logic                stall_drive_en
);

  phase_e phase_w;
  logic   stall_seen_w;
  logic   served_w;
  logic   captured_w;

  brg_id_capture #(.NUM_PINS(NUM_PINS)) u_id (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_n   (req_pins_n),
    .id       (agent_id),
    .valid    (id_valid),
    .error    (id_error),
    .captured (captured_w)
  );

  brg_stall_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_full (queue_full),
    .stall_in_n (stall_in_n),
    .drive_en   (stall_drive_en),
    .stall_seen (stall_seen_w),
    .phase      (phase_w)
  );

  brg_issue_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_pending (req_pending),
    .id_valid    (id_valid),
    .stall_seen  (stall_seen_w),
    .prio_req_n  (prio_req_n),
    .lock_active (lock_active),
    .grant       (issue_grant),
    .served      (served_w)
  );

endmodule

// File: rtl/bus_req_gate_chk.sv
module bus_req_gate_chk #(
  parameter int unsigned IDW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           prio_req_n,
  input logic           lock_active,
  input logic [IDW-1:0] agent_id,
  input logic           id_valid,
  input logic           id_error,
  input logic           issue_grant,
  input logic           stall_drive_en,
  input logic           phase,
  input logic           stall_seen,
  input logic           captured
);

  // R1
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> ($stable(agent_id) && $stable(id_valid)));

  // R2
  id_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && id_error));

  // R4
  drive_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stall_drive_en) |-> ($past(phase) == 1'b0));

  // R5
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_grant |-> !$past(stall_seen));

  // R6
  prio_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_grant |-> $past(prio_req_n || lock_active));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_grant |=> !issue_grant);

  // R10
  grant_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_grant |-> id_valid);

endmodule

bind bus_req_gate bus_req_gate_chk #(.IDW(IDW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .prio_req_n     (prio_req_n),
  .lock_active    (lock_active),
  .agent_id       (agent_id),
  .id_valid       (id_valid),
  .id_error       (id_error),
  .issue_grant    (issue_grant),
  .stall_drive_en (stall_drive_en),
  .phase          (phase_w),
  .stall_seen     (stall_seen_w),
  .captured       (captured_w)
);

// File: tb/bus_req_gate_bench.sv
module bus_req_gate_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_pins_n = 4'hF;
  logic       stall_in_n = 1'b1;
  logic       prio_req_n = 1'b1;
  logic       lock_active = 1'b0;
  logic       req_pending = 1'b0;
  logic       queue_full = 1'b0;
  logic [1:0] agent_id;
  logic       id_valid, id_error, issue_grant, stall_drive_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic prev_de = 1'b0;

  always #10 clk = ~clk;

  bus_req_gate u_bus_req_gate (
    .clk(clk), .rst_n(rst_n), .req_pins_n(req_pins_n), .stall_in_n(stall_in_n),
    .prio_req_n(prio_req_n), .lock_active(lock_active), .req_pending(req_pending),
    .queue_full(queue_full), .agent_id(agent_id), .id_valid(id_valid),
    .id_error(id_error), .issue_grant(issue_grant), .stall_drive_en(stall_drive_en)
  );

  // edges since reset release; at a negedge, cyc is the index of the next edge
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R4 monitor: the drive enable may only move across an even edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_de <= 1'b0;
    end else begin
      if (stall_drive_en !== prev_de) check("R4 drive edge parity", 4'((cyc - 1) % 2), 4'h0);
      prev_de <= stall_drive_en;
    end
  end

  task automatic do_reset(input logic [3:0] pins);
    @(negedge clk);
    rst_n = 1'b0;
    req_pending = 1'b0; queue_full = 1'b0; stall_in_n = 1'b1;
    prio_req_n = 1'b1; lock_active = 1'b0;
    req_pins_n = pins;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic align(input int parity);
    while ((cyc % 2) != parity) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0; req_pins_n = 4'b1101; req_pending = 1'b1; queue_full = 1'b1;
    @(negedge clk);
    check("R3 agent_id", {2'b0, agent_id}, 4'h0);
    check("R3 id_valid", {3'b0, id_valid}, 4'h0);
    check("R3 id_error", {3'b0, id_error}, 4'h0);
    check("R3 grant", {3'b0, issue_grant}, 4'h0);
    check("R3 drive", {3'b0, stall_drive_en}, 4'h0);
    req_pending = 1'b0; queue_full = 1'b0;
  endtask

  task automatic t_id_each();
    for (int i = 0; i < 4; i++) begin
      do_reset(~(4'b0001 << i));
      check("R1 agent_id", {2'b0, agent_id}, 4'(i));
      check("R1 id_valid", {3'b0, id_valid}, 4'h1);
      req_pins_n = 4'b1110 ^ 4'b0110;
      repeat (2) @(negedge clk);
      check("R1 id held", {2'b0, agent_id}, 4'(i));
    end
  endtask

  task automatic t_id_err(input logic [3:0] pins);
    do_reset(pins);
    check("R2 id_error", {3'b0, id_error}, 4'h1);
    check("R2 id_valid", {3'b0, id_valid}, 4'h0);
    check("R2 agent_id", {2'b0, agent_id}, 4'h0);
    req_pending = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 no grant without id", {3'b0, issue_grant}, 4'h0);
    req_pending = 1'b0;
  endtask

  task automatic t_grant_basic();
    do_reset(4'b1011);
    req_pending = 1'b1;
    @(negedge clk);
    check("R8 grant after edge", {3'b0, issue_grant}, 4'h1);
    @(negedge clk);
    check("R9 single pulse", {3'b0, issue_grant}, 4'h0);
    @(negedge clk);
    check("R9 no regrant while held", {3'b0, issue_grant}, 4'h0);
    req_pending = 1'b0;
    @(negedge clk);
    req_pending = 1'b1;
    @(negedge clk);
    check("R9 regrant after drop", {3'b0, issue_grant}, 4'h1);
    req_pending = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_drive();
    do_reset(4'b1110);
    align(0);
    queue_full = 1'b1;
    @(negedge clk);
    check("R4 drive on even edge", {3'b0, stall_drive_en}, 4'h1);
    queue_full = 1'b0;
    @(negedge clk);
    check("R4 hold on odd edge", {3'b0, stall_drive_en}, 4'h1);
    @(negedge clk);
    check("R4 release on even edge", {3'b0, stall_drive_en}, 4'h0);
  endtask

  task automatic t_sample();
    do_reset(4'b0111);
    align(0);
    stall_in_n = 1'b0; req_pending = 1'b1;
    @(negedge clk);
    stall_in_n = 1'b1;
    check("R5 even pulse ignored", {3'b0, issue_grant}, 4'h1);
    req_pending = 1'b0;
    repeat (2) @(negedge clk);
    align(1);
    stall_in_n = 1'b0;
    @(negedge clk);
    stall_in_n = 1'b1; req_pending = 1'b1;
    @(negedge clk);
    check("R5 stall blocks (even)", {3'b0, issue_grant}, 4'h0);
    @(negedge clk);
    check("R5 stall blocks (odd)", {3'b0, issue_grant}, 4'h0);
    @(negedge clk);
    check("R5 grant after clear", {3'b0, issue_grant}, 4'h1);
    req_pending = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_prio();
    do_reset(4'b1101);
    prio_req_n = 1'b0; req_pending = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 priority blocks", {3'b0, issue_grant}, 4'h0);
    end
    prio_req_n = 1'b1;
    @(negedge clk);
    check("R6 grant after release", {3'b0, issue_grant}, 4'h1);
    req_pending = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_lock();
    do_reset(4'b1101);
    prio_req_n = 1'b0; lock_active = 1'b1; req_pending = 1'b1;
    @(negedge clk);
    check("R7 locked passes priority", {3'b0, issue_grant}, 4'h1);
    req_pending = 1'b0; lock_active = 1'b0; prio_req_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    t_id_each();
    t_id_err(4'b1111);
    t_id_err(4'b1100);
    t_grant_basic();
    t_drive();
    t_sample();
    t_prio();
    t_lock();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule